// File: doc/BRIEF.md
# Indirect Configuration Access Bridge

This block sits on a host I/O bus and gives the host access to a small configuration space through two 32-bit ports. The host first writes a selector dword to the select port (I/O address 0CF8h). That dword holds an enable flag, a bus number, a device number, a function number and a register offset. Later accesses to the data port (0CFCh to 0CFFh) become configuration reads or writes aimed at the selected register. A byte or word access picks its byte lanes with the two low bits of the I/O address.

The bridge models `DEV_COUNT` device functions on bus 0, all at function number 0. Each one has a 256-byte register space, stored as 64 dwords. Dword 0 is a read-only identity word: the vendor code sits in the low half and a per-device code in the high half. The other dwords are plain read/write storage. A read that no device answers returns all-ones. Every data-port access also loads a status code: 00h for success, 86h when no target answers, 87h for a bad register offset.

Each access is a single-cycle strobe. Read data and the updated status appear on the clock edge that follows.

Top module: `cfg_port_bridge`

## Requirements
- R1: A dword write (ioSize=2, low address bits 00) to I/O address 0CF8h loads the selector register. A dword read there returns the selector register. Reset clears the selector to zero. Any other access size at 0CF8h is ignored: no read data and no status change.
- R2: Selector fields: bit 31 is the enable flag, bits 23:16 the bus, bits 15:11 the device, bits 10:8 the function and bits 7:0 the register offset. A target exists only if bus = 0, function = 0 and device < DEV_COUNT. When the flag is set, the offset is aligned and no target exists, a read returns all-ones, a write changes no storage, and the status becomes 86h.
- R3: When selector bit 31 is 0, a data-port read returns all-ones, a data-port write is discarded, and the status becomes 86h.
- R4: The status becomes 87h in any of these cases: selector bits 1:0 are nonzero, the access size is 3, a word (ioSize=1) uses an odd lane, or a dword uses a lane other than 0. In that case a read returns all-ones and a write is discarded.
- R5: Status priority: disabled (86h) comes first, then misalignment (87h), then a missing target (86h). Otherwise the status is 00h. A select-port access sets the status to 00h.
- R6: A data-port access at I/O address 0CFCh+L works on byte lane L of the selected dword. Read data is right-justified and zero-extended: a byte read puts the lane in bits 7:0, a word read puts lanes L and L+1 in bits 15:0. A write stores the right-justified bytes of ioWdata into only the addressed lanes.
- R7: Dword 0 of device d reads as {DEV_ID_BASE+d, VENDOR_ID}. Writes to dword 0 are ignored.
- R8: ioRvalid is high for exactly the cycle after a read at either port. ioRdata and cfgStatus update at that same edge. Accesses to other I/O addresses produce no read data and leave the status unchanged.
- R9: Dwords 1 to 63 of each device reset to zero, hold what is written to them, and are separate per device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioValid | input | 1 | One-cycle access strobe |
| ioWrite | input | 1 | 1 = write, 0 = read |
| ioAddr | input | 16 | Host I/O address |
| ioSize | input | 2 | 0 byte, 1 word, 2 dword, 3 invalid |
| ioWdata | input | 32 | Write data, right-justified |
| ioRdata | output | 32 | Read data, right-justified |
| ioRvalid | output | 1 | Read data valid |
| cfgStatus | output | 8 | Status of the last port access |

## Verification
The assertions assume that ioValid is low while reset is held. They also assume that the host never starts a new access in the same cycle as the previous one, because each property compares one access against the following edge. The bench drives every access for one cycle and follows it with at least one idle cycle. Every selector it writes keeps bits 30:24 at zero, so only the decoded fields vary.

// File: rtl/cfgbr_pkg.sv
package cfgbr_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_BAD   = 2'd3
  } accSize_e;

  localparam logic [7:0] ST_OK    = 8'h00;
  localparam logic [7:0] ST_NODEV = 8'h86;
  localparam logic [7:0] ST_BADREG = 8'h87;

  typedef struct packed {
    logic       addrWr;
    logic       addrRd;
    logic       cfgWr;
    logic       cfgRd;
    logic       cfgOk;
    logic [1:0] lane;
    accSize_e   size;
    logic       statusLoad;
    logic [7:0] statusVal;
  } ctrlStrobe_t;
endpackage

// File: rtl/cfgbr_ctrl.sv
module cfgbr_ctrl
  import cfgbr_pkg::*;
#(
  parameter logic [15:0] ADDR_PORT = 16'h0CF8,
  parameter logic [15:0] DATA_PORT = 16'h0CFC,
  parameter int          DEV_COUNT = 2
) (
  input  logic        ioValid,
  input  logic        ioWrite,
  input  logic [15:0] ioAddr,
  input  logic [1:0]  ioSize,
  input  logic [31:0] addrWord,
  output ctrlStrobe_t strb
);
  logic       hitAddr, hitData, enable, misalign, present;
  logic [7:0] busNum;
  logic [4:0] devNum;
  logic [2:0] fnNum;
  logic [1:0] lane;
  accSize_e   size;
  logic       unusedCtrl;

  assign unusedCtrl = ^addrWord[30:24];
  assign size    = accSize_e'(ioSize);
  assign lane    = ioAddr[1:0];
  assign busNum  = addrWord[23:16];
  assign devNum  = addrWord[15:11];
  assign fnNum   = addrWord[10:8];
  assign enable  = addrWord[31];

  assign hitAddr = ioValid && (ioAddr[15:2] == ADDR_PORT[15:2])
                   && (size == SZ_DWORD) && (lane == 2'b00);
  assign hitData = ioValid && (ioAddr[15:2] == DATA_PORT[15:2]);

  always_comb begin
    misalign = (addrWord[1:0] != 2'b00);
    case (size)
      SZ_WORD:  misalign = misalign || lane[0];
      SZ_DWORD: misalign = misalign || (lane != 2'b00);
      SZ_BAD:   misalign = 1'b1;
      default:  ;
    endcase
  end

  assign present = (busNum == 8'h00) && (fnNum == 3'd0) && (int'(devNum) < DEV_COUNT);

  always_comb begin
    strb            = '0;
    strb.lane       = lane;
    strb.size       = size;
    strb.addrWr     = hitAddr && ioWrite;
    strb.addrRd     = hitAddr && !ioWrite;
    strb.cfgRd      = hitData && !ioWrite;
    strb.statusLoad = hitAddr || hitData;
    if (hitAddr)       strb.statusVal = ST_OK;
    else if (!enable)  strb.statusVal = ST_NODEV;
    else if (misalign) strb.statusVal = ST_BADREG;
    else if (!present) strb.statusVal = ST_NODEV;
    else               strb.statusVal = ST_OK;
    strb.cfgOk = hitData && enable && !misalign && present;
    strb.cfgWr = strb.cfgOk && ioWrite;
  end
endmodule

// File: rtl/cfgbr_datapath.sv
module cfgbr_datapath
  import cfgbr_pkg::*;
#(
  parameter int          DEV_COUNT   = 2,
  parameter logic [15:0] VENDOR_ID   = 16'hA5C3,
  parameter logic [15:0] DEV_ID_BASE = 16'h7100
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strb,
  input  logic [31:0] ioWdata,
  output logic [31:0] addrWord,
  output logic [31:0] ioRdata,
  output logic        ioRvalid,
  output logic [7:0]  cfgStatus
);
  localparam int DW_PER_FN = 64;
  localparam int IDXW      = $clog2(DW_PER_FN);
  localparam int DEVW      = (DEV_COUNT > 1) ? $clog2(DEV_COUNT) : 1;

  logic [31:0]     regFile [DEV_COUNT][DW_PER_FN];
  logic [IDXW-1:0] dwIdx;
  logic [DEVW-1:0] devSel;
  logic [31:0]     rawDw, shifted, sizeMask, wdShift, rdNext;
  logic [3:0]      byteEn;

  assign dwIdx  = addrWord[2 +: IDXW];
  assign devSel = addrWord[11 +: DEVW];

  always_comb begin
    case (strb.size)
      SZ_BYTE: begin sizeMask = 32'h0000_00FF; byteEn = 4'b0001 << strb.lane; end
      SZ_WORD: begin sizeMask = 32'h0000_FFFF; byteEn = 4'b0011 << strb.lane; end
      default: begin sizeMask = 32'hFFFF_FFFF; byteEn = 4'b1111; end
    endcase
  end

  assign rawDw   = (dwIdx == '0) ? {DEV_ID_BASE + 16'(devSel), VENDOR_ID}
                                 : regFile[devSel][dwIdx];
  assign shifted = rawDw >> {strb.lane, 3'b000};
  assign wdShift = ioWdata << {strb.lane, 3'b000};

  always_comb begin
    if (strb.addrRd)     rdNext = addrWord;
    else if (strb.cfgOk) rdNext = shifted & sizeMask;
    else                 rdNext = sizeMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrWord  <= '0;
      ioRdata   <= '0;
      ioRvalid  <= 1'b0;
      cfgStatus <= ST_OK;
    end else begin
      ioRvalid <= strb.addrRd || strb.cfgRd;
      if (strb.addrRd || strb.cfgRd) ioRdata <= rdNext;
      if (strb.addrWr) addrWord <= ioWdata;
      if (strb.statusLoad) cfgStatus <= strb.statusVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int d = 0; d < DEV_COUNT; d++)
        for (int i = 0; i < DW_PER_FN; i++)
          regFile[d][i] <= '0;
    end else if (strb.cfgWr && (dwIdx != '0)) begin
      for (int b = 0; b < 4; b++)
        if (byteEn[b]) regFile[devSel][dwIdx][b*8 +: 8] <= wdShift[b*8 +: 8];
    end
  end
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfgbr_pkg::*;
#(
  parameter logic [15:0] ADDR_PORT   = 16'h0CF8,
  parameter logic [15:0] DATA_PORT   = 16'h0CFC,
  parameter int          DEV_COUNT   = 2,
  parameter logic [15:0] VENDOR_ID   = 16'hA5C3,
  parameter logic [15:0] DEV_ID_BASE = 16'h7100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ioValid,
  input  logic        ioWrite,
  input  logic [15:0] ioAddr,
  input  logic [1:0]  ioSize,
  input  logic [31:0] ioWdata,
  output logic [31:0] ioRdata,
  output logic        ioRvalid,
  output logic [7:0]  cfgStatus
);
  ctrlStrobe_t strb;
  logic [31:0] addrWord;

  cfgbr_ctrl #(.ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT), .DEV_COUNT(DEV_COUNT)) u_ctrl (
    .ioValid(ioValid), .ioWrite(ioWrite), .ioAddr(ioAddr), .ioSize(ioSize),
    .addrWord(addrWord), .strb(strb)
  );

  cfgbr_datapath #(.DEV_COUNT(DEV_COUNT), .VENDOR_ID(VENDOR_ID), .DEV_ID_BASE(DEV_ID_BASE)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ioWdata(ioWdata),
    .addrWord(addrWord), .ioRdata(ioRdata), .ioRvalid(ioRvalid), .cfgStatus(cfgStatus)
  );
endmodule

// File: rtl/cfgbr_checker.sv
module cfgbr_checker #(
  parameter logic [15:0] ADDR_PORT = 16'h0CF8,
  parameter logic [15:0] DATA_PORT = 16'h0CFC
) (
  input logic        clk,
  input logic        rstN,
  input logic        ioValid,
  input logic        ioWrite,
  input logic [15:0] ioAddr,
  input logic [1:0]  ioSize,
  input logic [31:0] ioWdata,
  input logic [31:0] ioRdata,
  input logic        ioRvalid,
  input logic [7:0]  cfgStatus,
  input logic [31:0] addrWord
);
  logic selWr, dataHit;
  assign selWr   = ioValid && ioWrite && (ioAddr == ADDR_PORT) && (ioSize == 2'd2);
  assign dataHit = ioValid && (ioAddr[15:2] == DATA_PORT[15:2]);

  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    selWr |=> (addrWord == $past(ioWdata)));  // R1
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !selWr |=> $stable(addrWord));  // R1
  AST_MISSING_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (dataHit && !ioWrite && ioSize == 2'd2 && ioAddr[1:0] == 2'b00 && addrWord[31]
     && addrWord[1:0] == 2'b00 && addrWord[23:16] != 8'h00)
    |=> (ioRdata == 32'hFFFF_FFFF && cfgStatus == 8'h86));  // R2
  AST_DISABLED_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (dataHit && !ioWrite && ioSize == 2'd2 && !addrWord[31])
    |=> (ioRdata == 32'hFFFF_FFFF && cfgStatus == 8'h86));  // R3
  AST_BAD_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    (dataHit && addrWord[31] && addrWord[1:0] != 2'b00) |=> (cfgStatus == 8'h87));  // R4
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (cfgStatus == 8'h00 || cfgStatus == 8'h86 || cfgStatus == 8'h87));  // R5
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    ioRvalid |-> $past(ioValid && !ioWrite));  // R8
endmodule

bind cfg_port_bridge cfgbr_checker #(.ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)) u_chk (
  .clk(clk), .rstN(rstN), .ioValid(ioValid), .ioWrite(ioWrite), .ioAddr(ioAddr),
  .ioSize(ioSize), .ioWdata(ioWdata), .ioRdata(ioRdata), .ioRvalid(ioRvalid),
  .cfgStatus(cfgStatus), .addrWord(addrWord)
);

// File: tb/sim_cfg_port_bridge.sv
module sim_cfg_port_bridge;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioValid = 1'b0, ioWrite = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [1:0]  ioSize = '0;
  logic [31:0] ioWdata = '0;
  logic [31:0] ioRdata;
  logic        ioRvalid;
  logic [7:0]  cfgStatus;

  int checks = 0, errors = 0;
  logic [31:0] mMem [0:1][0:63];
  logic [31:0] mSel = '0;
  logic [7:0]  mStat = 8'h00;

  always #10 clk = ~clk;

  cfg_port_bridge u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic refStep(input logic wr, input logic [15:0] a, input logic [1:0] sz,
                         input logic [31:0] wd, output logic expV, output logic [31:0] expD);
    int dev, idx, lane, nb;
    logic bad, present;
    logic [7:0] st;
    logic [31:0] mask, dw;
    expV = 0; expD = 0;
    lane = int'(a[1:0]);
    if (a[15:2] == 14'(16'h0CF8 >> 2)) begin
      if (sz == 2 && lane == 0) begin
        if (wr) mSel = wd; else begin expV = 1; expD = mSel; end
        mStat = 8'h00;
      end
    end else if (a[15:2] == 14'(16'h0CFC >> 2)) begin
      dev = int'(mSel[15:11]); idx = int'(mSel[7:2]);
      mask = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
      nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      bad = (mSel[1:0] != 0) || sz == 3 || (sz == 1 && lane % 2 == 1) || (sz == 2 && lane != 0);
      present = mSel[23:16] == 0 && mSel[10:8] == 0 && dev < 2;
      if (!mSel[31]) st = 8'h86;
      else if (bad) st = 8'h87;
      else if (!present) st = 8'h86;
      else st = 8'h00;
      if (!wr) begin
        expV = 1;
        if (st == 8'h00) begin
          dw = (idx == 0) ? {16'h7100 + 16'(dev), 16'hA5C3} : mMem[dev][idx];
          expD = (dw >> (lane * 8)) & mask;
        end else expD = mask;
      end else if (st == 8'h00 && idx != 0) begin
        for (int b = 0; b < nb; b++) mMem[dev][idx][(lane + b) * 8 +: 8] = wd[b * 8 +: 8];
      end
      mStat = st;
    end
  endtask

  task automatic acc(input logic wr, input logic [15:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, input string tag);
    logic expV;
    logic [31:0] expD;
    @(negedge clk);
    chk(ioRvalid == 1'b0, {tag, " idle rvalid (R8)"}, 32'(ioRvalid), 0);
    chk(cfgStatus == mStat, {tag, " idle status (R8)"}, 32'(cfgStatus), 32'(mStat));
    ioValid = 1; ioWrite = wr; ioAddr = a; ioSize = sz; ioWdata = wd;
    refStep(wr, a, sz, wd, expV, expD);
    @(negedge clk);
    ioValid = 0; ioWrite = 0;
    chk(ioRvalid == expV, {tag, " rvalid"}, 32'(ioRvalid), 32'(expV));
    if (expV) chk(ioRdata == expD, {tag, " rdata"}, ioRdata, expD);
    chk(cfgStatus == mStat, {tag, " status"}, 32'(cfgStatus), 32'(mStat));
  endtask

  task automatic sel(input logic [31:0] v); acc(1, 16'h0CF8, 2, v, "R1 select write"); endtask
  task automatic rd(input logic [1:0] l, input logic [1:0] sz, input string tag);
    acc(0, 16'h0CFC + 16'(l), sz, 0, tag);
  endtask
  task automatic wr(input logic [1:0] l, input logic [1:0] sz, input logic [31:0] d, input string tag);
    acc(1, 16'h0CFC + 16'(l), sz, d, tag);
  endtask

  initial begin
    for (int d = 0; d < 2; d++) for (int i = 0; i < 64; i++) mMem[d][i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    chk(ioRvalid == 0 && cfgStatus == 8'h00, "reset state (R8)", {23'd0, ioRvalid, cfgStatus}, 0);
    acc(0, 16'h0CF8, 2, 0, "R1 select reset zero");
    sel(32'h8000_0000);
    acc(0, 16'h0CF8, 2, 0, "R1 select readback");
    rd(0, 2, "R7 id dword dev0");
    rd(2, 1, "R6 word lane2 id");
    rd(1, 0, "R6 byte lane1 id");
    wr(0, 2, 32'h1234_5678, "R7 id write ignored");
    rd(0, 2, "R7 id after write");
    sel(32'h8000_0010);
    rd(0, 2, "R9 reset zero");
    wr(0, 2, 32'hDEAD_BEEF, "R9 dword write");
    rd(0, 2, "R9 dword read");
    wr(1, 0, 32'hFFFF_FF5A, "R6 byte write lane1");
    wr(2, 1, 32'h0000_C3D2, "R6 word write lane2");
    rd(0, 2, "R6 lanes merged");
    rd(3, 0, "R6 byte lane3");
    sel(32'h8000_0810);
    rd(0, 2, "R9 dev1 separate");
    rd(0, 2, "R7 dev1 ignores"); // offset 10h still; next id
    sel(32'h8000_0800);
    rd(0, 2, "R7 id dword dev1");
    sel(32'h8000_1000);
    rd(0, 2, "R2 missing device");
    sel(32'h8001_0000);
    rd(0, 1, "R2 missing bus word");
    sel(32'h8000_0110);
    wr(0, 2, 32'h0BAD_0BAD, "R2 missing function write");
    rd(0, 2, "R2 missing function read");
    sel(32'h0000_0010);
    rd(0, 2, "R3 disabled read");
    wr(0, 2, 32'h5555_5555, "R3 disabled write");
    rd(0, 0, "R3 disabled byte read");
    sel(32'h8000_0010);
    rd(0, 2, "R3 storage untouched");
    rd(3, 1, "R4 word odd lane");
    rd(1, 2, "R4 dword lane1");
    wr(0, 3, 32'h1111_1111, "R4 size three write");
    wr(1, 2, 32'h2222_2222, "R4 misaligned write");
    rd(0, 2, "R4 storage untouched");
    sel(32'h8000_0012);
    rd(0, 0, "R4 selector low bits");
    sel(32'h0000_0012);
    rd(0, 2, "R5 disabled beats misaligned");
    sel(32'h8000_1002);
    rd(0, 2, "R5 misaligned beats missing");
    acc(0, 16'h0CF8, 1, 0, "R1 word at select ignored");
    acc(0, 16'h0080, 2, 0, "R8 other address read");
    acc(1, 16'h0CF4, 2, 32'h8000_0000, "R8 other address write");
    acc(0, 16'h0CF8, 2, 0, "R1 select unchanged");
    sel(32'h8000_0010);
    rd(0, 2, "R5 success status");
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule